// File: doc/BRIEF.md
# Memory Command Decoder with Bank-State Tracking

This block sits behind the command and address pins of a double-data-rate memory device model or monitor. On every rising clock edge it captures the chip-select, the three active-low strobes (row, column, write), the bank select, the address bus and the clock-enable. It turns them into one registered command report per cycle. The report carries the command kind, the target bank, the row, column or op-code carried on the address bus, and the per-command meaning of address bits 10 and 12: auto-precharge, chopped burst or precharge-all.

The block keeps an open/idle flag and a latched row for each bank. Reads and writes report the row that is open in their bank. Commands that break the bank rules are flagged. When clock-enable drops, the block reports the low-power state entered. That state is a precharge power-down if every bank is idle and an active power-down if any bank is open. A refresh issued on the falling clock-enable edge with all banks idle is reported as self-refresh entry.

All outputs are registered. They reflect the pins sampled on the most recent rising edge.

Top module: `dram_cmd_decoder`

## Requirements
- R1: While reset is asserted (asynchronous, active low), cmd_kind is 0, cmd_valid and cmd_illegal are 0, bank_open is all zero and pd_mode is 0. Asserting reset mid-run closes every bank at once.
- R2: With clock-enable sampled high and cs_n sampled high, cmd_kind is 1 (deselect) whatever the other pins carry, and the bank state does not change.
- R3: With cs_n low and clock-enable high, {ras_n,cas_n,we_n} decodes as follows: 011 activate (kind 3), 101 read (4), 110 reserved (9), 100 write (5), 010 precharge (6), 001 refresh (7), 000 mode-register set (8), 111 no-op (2). cmd_valid is 1 exactly for kinds 3 to 8 and 10.
- R4: A legal activate sets bank_open bit ba and latches the address as that bank's row. cmd_addr and cmd_bank report the row and the bank. A later read or write to that bank reports the latched row on cmd_row. cmd_row is 0 for other commands and for idle banks.
- R5: For a read or write, cmd_addr is the address with bits 10 and 12 cleared, cmd_autopre equals address bit 10, and cmd_chop is the inverse of address bit 12. A legal access with auto-precharge marks its bank idle.
- R6: For a precharge, address bit 10 high sets cmd_pre_all and marks every bank idle. Address bit 10 low marks only bank ba idle.
- R7: For a mode-register set, cmd_mr_idx carries ba, cmd_addr carries the op-code and cmd_bank is 0.
- R8: cmd_illegal is raised for a read or write to an idle bank, an activate to an open bank, and the reserved code. An illegal command changes no bank state.
- R9: When clock-enable falls, pd_mode becomes 1 (precharge power-down) if all banks are idle, or 2 (active power-down) if any bank is open. The mode holds while clock-enable stays low and returns to 0 on the first edge where it is sampled high.
- R10: A refresh code on the edge where clock-enable falls gives cmd_kind 10 and pd_mode 3 (self-refresh) when all banks are idle. With any bank open it gives cmd_kind 0, cmd_illegal 1 and pd_mode 2.
- R11: On every edge where clock-enable is sampled low, the command pins are ignored. cmd_kind is 0 (except the case in R10) and the bank state is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BANK_W | Bank select, or mode-register index |
| addr | input | ADDR_W | Row, column or op-code bus |
| cmd_valid | output | 1 | An operative command was decoded |
| cmd_kind | output | 4 | Command kind code |
| cmd_bank | output | BANK_W | Target bank of activate, read, write or precharge |
| cmd_addr | output | ADDR_W | Row, column or op-code |
| cmd_row | output | ADDR_W | Open row of the accessed bank on read or write |
| cmd_autopre | output | 1 | Auto-precharge requested |
| cmd_chop | output | 1 | Chopped burst requested |
| cmd_pre_all | output | 1 | Precharge applies to all banks |
| cmd_mr_idx | output | BANK_W | Mode register addressed |
| cmd_illegal | output | 1 | Command breaks the bank rules or is reserved |
| bank_open | output | NUM_BANKS | Per-bank open-row flags |
| pd_mode | output | 2 | Low-power state: 0 on, 1 precharge PD, 2 active PD, 3 self-refresh |

## Verification
A wrong bank flag shows up at the latest on the next access to that bank, as a spurious or missing illegal flag, a wrong cmd_row, or a wrong power-down kind at the next clock-enable fall. bank_open shows it one cycle after the command that corrupted it. A wrong clock-enable history shows up in pd_mode on the first edge after the pin changes. It also shows when a command issued during power-down leaks out as a decoded command. The stimulus walks bank-state sequences so that each such corruption reaches a port within one or two cycles.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

   typedef enum logic [3:0] {
      K_NONE  = 4'd0,
      K_DESEL = 4'd1,
      K_NOP   = 4'd2,
      K_ACT   = 4'd3,
      K_RD    = 4'd4,
      K_WR    = 4'd5,
      K_PRE   = 4'd6,
      K_REF   = 4'd7,
      K_MRS   = 4'd8,
      K_RSVD  = 4'd9,
      K_SREF  = 4'd10
   } cmd_kind_e;

   typedef enum logic [1:0] {
      PM_ON       = 2'd0,
      PM_PRE_PD   = 2'd1,
      PM_ACT_PD   = 2'd2,
      PM_SELF_REF = 2'd3
   } pwr_mode_e;

   // Raw pin code to command kind, before bank rules and clock-enable gating
   function automatic cmd_kind_e pin_decode(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
      cmd_kind_e k;
      if (cs_n) begin
         k = K_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b011:  k = K_ACT;
            3'b101:  k = K_RD;
            3'b100:  k = K_WR;
            3'b010:  k = K_PRE;
            3'b001:  k = K_REF;
            3'b000:  k = K_MRS;
            3'b111:  k = K_NOP;
            default: k = K_RSVD;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/dcd_bank_slot.sv
module dcd_bank_slot #(
   parameter int ROW_W      = 16,
   parameter bit TRACK_ROWS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_open,
   input  logic             clr_open,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_q,
   output logic [ROW_W-1:0] row_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (set_open) begin
         open_q <= 1'b1;
      end else if (clr_open) begin
         open_q <= 1'b0;
      end
   end

   generate
      if (TRACK_ROWS) begin : g_row_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= '0;
            end else if (set_open) begin
               row_q <= row_in;
            end
         end
      end else begin : g_no_row
         logic unused_row;
         assign unused_row = ^row_in;
         assign row_q      = '0;
      end
   endgenerate

endmodule

// File: rtl/dcd_power_track.sv
module dcd_power_track (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       sref_go,
   input  logic       any_open,
   output logic       cke_prev,
   output logic [1:0] mode
);
   import dcd_pkg::*;

   pwr_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_prev <= 1'b0;
         mode_q   <= PM_ON;
      end else begin
         cke_prev <= cke;
         if (cke) begin
            mode_q <= PM_ON;
         end else if (cke_prev) begin
            if (sref_go)       mode_q <= PM_SELF_REF;
            else if (any_open) mode_q <= PM_ACT_PD;
            else               mode_q <= PM_PRE_PD;
         end
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/dcd_cmd_decode.sv
module dcd_cmd_decode #(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 16,
   parameter int AP_BIT    = 10,
   parameter int BC_BIT    = 12,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 cke,
   input  logic                 cke_prev,
   input  logic [BANK_W-1:0]    ba,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_BANKS-1:0] open_vec,
   output dcd_pkg::cmd_kind_e   kind,
   output logic                 valid,
   output logic                 illegal,
   output logic [BANK_W-1:0]    out_bank,
   output logic [ADDR_W-1:0]    out_addr,
   output logic                 autopre,
   output logic                 chop,
   output logic                 pre_all,
   output logic [BANK_W-1:0]    mr_idx,
   output logic [NUM_BANKS-1:0] set_vec,
   output logic [NUM_BANKS-1:0] clr_vec
);
   import dcd_pkg::*;

   localparam logic [ADDR_W-1:0] COL_MASK =
      ~((ADDR_W'(1) << AP_BIT) | (ADDR_W'(1) << BC_BIT));

   cmd_kind_e              raw;
   logic                   sel_open;
   logic                   any_open;
   logic [NUM_BANKS-1:0]   bank_oh;

   assign raw      = pin_decode(cs_n, ras_n, cas_n, we_n);
   assign sel_open = open_vec[ba];
   assign any_open = |open_vec;
   assign bank_oh  = NUM_BANKS'(1) << ba;

   always_comb begin
      kind     = K_NONE;
      illegal  = 1'b0;
      out_bank = '0;
      out_addr = '0;
      autopre  = 1'b0;
      chop     = 1'b0;
      pre_all  = 1'b0;
      mr_idx   = '0;
      set_vec  = '0;
      clr_vec  = '0;
      if (!cke) begin
         // Pins ignored in power-down; only the entry edge is examined
         if (cke_prev && raw == K_REF) begin
            if (any_open) illegal = 1'b1;
            else          kind    = K_SREF;
         end
      end else begin
         kind = raw;
         case (raw)
            K_ACT: begin
               out_bank = ba;
               out_addr = addr;
               if (sel_open) illegal = 1'b1;
               else          set_vec = bank_oh;
            end
            K_RD, K_WR: begin
               out_bank = ba;
               out_addr = addr & COL_MASK;
               autopre  = addr[AP_BIT];
               chop     = ~addr[BC_BIT];
               if (!sel_open)         illegal = 1'b1;
               else if (addr[AP_BIT]) clr_vec = bank_oh;
            end
            K_PRE: begin
               out_bank = ba;
               pre_all  = addr[AP_BIT];
               clr_vec  = addr[AP_BIT] ? '1 : bank_oh;
            end
            K_MRS: begin
               mr_idx   = ba;
               out_addr = addr;
            end
            K_RSVD: illegal = 1'b1;
            default: ;
         endcase
      end
   end

   assign valid = (kind == K_ACT) || (kind == K_RD)  || (kind == K_WR) ||
                  (kind == K_PRE) || (kind == K_REF) || (kind == K_MRS) ||
                  (kind == K_SREF);

endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder #(
   parameter int NUM_BANKS  = 8,
   parameter int ADDR_W     = 16,
   parameter int AP_BIT     = 10,
   parameter int BC_BIT     = 12,
   parameter bit TRACK_ROWS = 1'b1,
   localparam int BANK_W    = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BANK_W-1:0]    ba,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 cmd_valid,
   output logic [3:0]           cmd_kind,
   output logic [BANK_W-1:0]    cmd_bank,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic [ADDR_W-1:0]    cmd_row,
   output logic                 cmd_autopre,
   output logic                 cmd_chop,
   output logic                 cmd_pre_all,
   output logic [BANK_W-1:0]    cmd_mr_idx,
   output logic                 cmd_illegal,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [1:0]           pd_mode
);
   import dcd_pkg::*;

   // Elaboration-time parameter checks
   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (AP_BIT >= ADDR_W || BC_BIT >= ADDR_W || AP_BIT == BC_BIT) begin : g_bad_bits
         $error("AP_BIT and BC_BIT must be distinct and inside the address bus");
      end
   endgenerate

   logic                 cke_prev;
   logic [NUM_BANKS-1:0] open_vec;
   logic [ADDR_W-1:0]    slot_row [NUM_BANKS];

   cmd_kind_e            d_kind;
   logic                 d_valid, d_illegal, d_ap, d_chop, d_all;
   logic [BANK_W-1:0]    d_bank, d_mr;
   logic [ADDR_W-1:0]    d_addr, d_row;
   logic [NUM_BANKS-1:0] set_vec, clr_vec;

   dcd_cmd_decode #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .AP_BIT    (AP_BIT),
      .BC_BIT    (BC_BIT)
   ) i_decode (
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .cke      (cke),
      .cke_prev (cke_prev),
      .ba       (ba),
      .addr     (addr),
      .open_vec (open_vec),
      .kind     (d_kind),
      .valid    (d_valid),
      .illegal  (d_illegal),
      .out_bank (d_bank),
      .out_addr (d_addr),
      .autopre  (d_ap),
      .chop     (d_chop),
      .pre_all  (d_all),
      .mr_idx   (d_mr),
      .set_vec  (set_vec),
      .clr_vec  (clr_vec)
   );

   dcd_power_track i_power (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .sref_go  (d_kind == K_SREF),
      .any_open (|open_vec),
      .cke_prev (cke_prev),
      .mode     (pd_mode)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      dcd_bank_slot #(
         .ROW_W      (ADDR_W),
         .TRACK_ROWS (TRACK_ROWS)
      ) i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_open (set_vec[b]),
         .clr_open (clr_vec[b]),
         .row_in   (addr),
         .open_q   (open_vec[b]),
         .row_q    (slot_row[b])
      );
   end

   // Row of the accessed bank, only for reads and writes that hit an open bank
   assign d_row = ((d_kind == K_RD || d_kind == K_WR) && open_vec[ba]) ? slot_row[ba] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid   <= 1'b0;
         cmd_kind    <= K_NONE;
         cmd_bank    <= '0;
         cmd_addr    <= '0;
         cmd_row     <= '0;
         cmd_autopre <= 1'b0;
         cmd_chop    <= 1'b0;
         cmd_pre_all <= 1'b0;
         cmd_mr_idx  <= '0;
         cmd_illegal <= 1'b0;
      end else begin
         cmd_valid   <= d_valid;
         cmd_kind    <= d_kind;
         cmd_bank    <= d_bank;
         cmd_addr    <= d_addr;
         cmd_row     <= d_row;
         cmd_autopre <= d_ap;
         cmd_chop    <= d_chop;
         cmd_pre_all <= d_all;
         cmd_mr_idx  <= d_mr;
         cmd_illegal <= d_illegal;
      end
   end

   assign bank_open = open_vec;

endmodule

// File: rtl/dram_cmd_decoder_chk.sv
module dram_cmd_decoder_chk #(
   parameter int NUM_BANKS = 8,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke,
   input logic                 cs_n,
   input logic [3:0]           cmd_kind,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 cmd_pre_all,
   input logic                 cmd_illegal,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [1:0]           pd_mode
);
   import dcd_pkg::*;

   logic [NUM_BANKS-1:0] open_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_prev <= '0;
      else        open_prev <= bank_open;
   end

   AST_DESEL_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(cke) && $past(cs_n) |-> cmd_kind == K_DESEL); // R2

   AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_kind == K_ACT |-> bank_open[cmd_bank]); // R4

   AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_kind == K_PRE && cmd_pre_all |-> bank_open == '0); // R6

   AST_IDLE_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_kind == K_RD || cmd_kind == K_WR) && !open_prev[cmd_bank] |-> cmd_illegal); // R8

   AST_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(cke) |-> pd_mode == PM_ON); // R9

   AST_SREF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_kind == K_SREF |-> pd_mode == PM_SELF_REF && bank_open == '0); // R10

   AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(cke) |-> (cmd_kind == K_NONE || cmd_kind == K_SREF)
                                      && $stable(bank_open)); // R11

endmodule

bind dram_cmd_decoder dram_cmd_decoder_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cs_n        (cs_n),
   .cmd_kind    (cmd_kind),
   .cmd_bank    (cmd_bank),
   .cmd_pre_all (cmd_pre_all),
   .cmd_illegal (cmd_illegal),
   .bank_open   (bank_open),
   .pd_mode     (pd_mode)
);

// File: tb/test_dram_cmd_decoder.sv
`timescale 1ns/1ps
module test_dram_cmd_decoder;

   localparam int KN = 0, KDS = 1, KNOP = 2, KACT = 3, KRD = 4, KWR = 5;
   localparam int KPRE = 6, KREF = 7, KMRS = 8, KRSV = 9, KSR = 10;
   localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101;
   localparam logic [3:0] P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001;
   localparam logic [3:0] P_MRS = 4'b0000, P_RSV = 4'b0110;

   typedef struct packed {
      logic [3:0]  pins;  // cs_n, ras_n, cas_n, we_n
      logic        ck;
      logic [2:0]  b;
      logic [15:0] a;
      logic [3:0]  k;
      logic        il;
      logic [7:0]  op;
      logic [1:0]  pd;
      logic [15:0] ad;
      logic        ap;
      logic        ch;
      logic        al;
      logic [2:0]  eb;
      logic [2:0]  mr;
      logic [15:0] rw;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VT [NV] = '{
      '{P_NOP,   1'b1, 3'd0, 16'h0000, 4'd2, 1'b0, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000},
      '{4'b1011, 1'b1, 3'd1, 16'h0055, 4'd1, 1'b0, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd2, 16'h0123, 4'd3, 1'b0, 8'h04, 2'd0, 16'h0123, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd5, 16'h0abc, 4'd3, 1'b0, 8'h24, 2'd0, 16'h0abc, 1'b0, 1'b0, 1'b0, 3'd5, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd2, 16'h0777, 4'd3, 1'b1, 8'h24, 2'd0, 16'h0777, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0000},
      '{P_RD,    1'b1, 3'd3, 16'h1000, 4'd4, 1'b1, 8'h24, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd3, 3'd0, 16'h0000},
      '{P_RD,    1'b1, 3'd2, 16'h1008, 4'd4, 1'b0, 8'h24, 2'd0, 16'h0008, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0123},
      '{P_WR,    1'b1, 3'd5, 16'h0410, 4'd5, 1'b0, 8'h04, 2'd0, 16'h0010, 1'b1, 1'b1, 1'b0, 3'd5, 3'd0, 16'h0abc},
      '{P_PRE,   1'b1, 3'd2, 16'h0000, 4'd6, 1'b0, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd7, 16'h0fff, 4'd3, 1'b0, 8'h80, 2'd0, 16'h0fff, 1'b0, 1'b0, 1'b0, 3'd7, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd0, 16'h0001, 4'd3, 1'b0, 8'h81, 2'd0, 16'h0001, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000},
      '{P_PRE,   1'b1, 3'd3, 16'h0400, 4'd6, 1'b0, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 3'd3, 3'd0, 16'h0000},
      '{P_MRS,   1'b1, 3'd2, 16'h0a5a, 4'd8, 1'b0, 8'h00, 2'd0, 16'h0a5a, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 16'h0000},
      '{P_REF,   1'b1, 3'd0, 16'h0000, 4'd7, 1'b0, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000},
      '{P_RSV,   1'b1, 3'd0, 16'h0000, 4'd9, 1'b1, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd1, 16'h0011, 4'd3, 1'b0, 8'h02, 2'd0, 16'h0011, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 16'h0000},
      '{P_ACT,   1'b1, 3'd4, 16'h0044, 4'd3, 1'b0, 8'h12, 2'd0, 16'h0044, 1'b0, 1'b0, 1'b0, 3'd4, 3'd0, 16'h0000},
      '{P_PRE,   1'b1, 3'd1, 16'h0000, 4'd6, 1'b0, 8'h10, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 16'h0000},
      '{P_PRE,   1'b1, 3'd0, 16'h0400, 4'd6, 1'b0, 8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]  ba = '0;
   logic [15:0] addr = '0;
   logic        cmd_valid, cmd_autopre, cmd_chop, cmd_pre_all, cmd_illegal;
   logic [3:0]  cmd_kind;
   logic [2:0]  cmd_bank, cmd_mr_idx;
   logic [15:0] cmd_addr, cmd_row;
   logic [7:0]  bank_open;
   logic [1:0]  pd_mode;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dram_cmd_decoder i_dram_cmd_decoder (
      .clk, .rst_n, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba, .addr,
      .cmd_valid, .cmd_kind, .cmd_bank, .cmd_addr, .cmd_row, .cmd_autopre,
      .cmd_chop, .cmd_pre_all, .cmd_mr_idx, .cmd_illegal, .bank_open, .pd_mode
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Drive at the falling edge, let one rising edge register, sample 1 ns later
   task automatic step(input logic [3:0] p, input logic ck,
                       input logic [2:0] b, input logic [15:0] a);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = p;
      cke  = ck;
      ba   = b;
      addr = a;
      @(posedge clk);
      #1;
   endtask

   function automatic logic valid_of(input int k);
      return (k >= KACT && k <= KMRS) || k == KSR;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "kind in reset", 32'(cmd_kind), KN);
      chk("R1", "valid in reset", 32'(cmd_valid), 0);
      chk("R1", "open in reset", 32'(bank_open), 0);
      chk("R1", "pd in reset", 32'(pd_mode), 0);
      chk("R1", "illegal in reset", 32'(cmd_illegal), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Vector table: decode, attributes, bank tracking
      for (int i = 0; i < NV; i++) begin
         step(VT[i].pins, VT[i].ck, VT[i].b, VT[i].a);
         chk("R3", "kind",      32'(cmd_kind),    32'(VT[i].k));
         chk("R3", "valid",     32'(cmd_valid),   32'(valid_of(int'(VT[i].k))));
         chk("R8", "illegal",   32'(cmd_illegal), 32'(VT[i].il));
         chk("R4", "bank_open", 32'(bank_open),   32'(VT[i].op));
         chk("R9", "pd_mode",   32'(pd_mode),     32'(VT[i].pd));
         chk("R5", "cmd_addr",  32'(cmd_addr),    32'(VT[i].ad));
         chk("R5", "autopre",   32'(cmd_autopre), 32'(VT[i].ap));
         chk("R5", "chop",      32'(cmd_chop),    32'(VT[i].ch));
         chk("R6", "pre_all",   32'(cmd_pre_all), 32'(VT[i].al));
         chk("R4", "cmd_bank",  32'(cmd_bank),    32'(VT[i].eb));
         chk("R7", "mr_idx",    32'(cmd_mr_idx),  32'(VT[i].mr));
         chk("R4", "cmd_row",   32'(cmd_row),     32'(VT[i].rw));
      end

      // R9/R11: power-down with every bank idle, pins ignored while low
      step(P_NOP, 1'b0, 3'd0, 16'h0000);
      chk("R9", "idle fall pd", 32'(pd_mode), 1);
      chk("R11", "kind at fall", 32'(cmd_kind), KN);
      step(P_ACT, 1'b0, 3'd1, 16'h0099);
      chk("R11", "act ignored kind", 32'(cmd_kind), KN);
      chk("R11", "act ignored open", 32'(bank_open), 0);
      chk("R9", "pd held", 32'(pd_mode), 1);
      step(P_NOP, 1'b1, 3'd0, 16'h0000);
      chk("R9", "exit pd", 32'(pd_mode), 0);
      chk("R3", "nop after exit", 32'(cmd_kind), KNOP);

      // Active power-down
      step(P_ACT, 1'b1, 3'd3, 16'h0033);
      chk("R4", "open b3", 32'(bank_open), 32'h08);
      // R2: deselect carrying a write with auto-precharge leaves bank open
      step(4'b1100, 1'b1, 3'd3, 16'h0400);
      chk("R2", "desel kind", 32'(cmd_kind), KDS);
      chk("R2", "desel keeps bank", 32'(bank_open), 32'h08);
      step(P_NOP, 1'b0, 3'd0, 16'h0000);
      chk("R9", "open fall pd", 32'(pd_mode), 2);
      step(P_NOP, 1'b1, 3'd0, 16'h0000);
      chk("R9", "exit active pd", 32'(pd_mode), 0);

      // R10: refresh at the fall with a bank open
      step(P_REF, 1'b0, 3'd0, 16'h0000);
      chk("R10", "sref refused kind", 32'(cmd_kind), KN);
      chk("R10", "sref refused illegal", 32'(cmd_illegal), 1);
      chk("R10", "sref refused pd", 32'(pd_mode), 2);
      chk("R10", "sref refused open", 32'(bank_open), 32'h08);
      step(P_NOP, 1'b1, 3'd0, 16'h0000);
      step(P_PRE, 1'b1, 3'd0, 16'h0400);
      chk("R6", "close all", 32'(bank_open), 0);

      // R10: self-refresh entry with all idle
      step(P_REF, 1'b0, 3'd0, 16'h0000);
      chk("R10", "sref kind", 32'(cmd_kind), KSR);
      chk("R10", "sref valid", 32'(cmd_valid), 1);
      chk("R10", "sref pd", 32'(pd_mode), 3);
      step(P_NOP, 1'b0, 3'd0, 16'h0000);
      chk("R11", "sref hold kind", 32'(cmd_kind), KN);
      chk("R10", "sref hold pd", 32'(pd_mode), 3);
      step(P_NOP, 1'b1, 3'd0, 16'h0000);
      chk("R9", "sref exit", 32'(pd_mode), 0);

      // R1: asynchronous reset mid-run closes banks
      step(P_ACT, 1'b1, 3'd6, 16'h0066);
      chk("R4", "open b6", 32'(bank_open), 32'h40);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "reset closes banks", 32'(bank_open), 0);
      chk("R1", "reset kind", 32'(cmd_kind), KN);
      @(negedge clk);
      rst_n = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule